// File: doc/BRIEF.md
# Ring oscillator entropy sample packer

This block turns a wide bank of free-running entropy bits into 64-bit words for a host to read. The 128 source bits arrive already synchronized, one value per clock, and are split into 16 groups of 8. In raw mode the block samples only the selected group, once per enabled cycle. Eight consecutive samples of those 8 sources are packed into one word, and each finished word is pushed into a 64-word on-chip FIFO.

In non-raw mode a stand-in for a conditioning engine supplies the words. It is a 64-bit LFSR that releases one word every 81 enabled cycles. Production runs while the FIFO has room, stalls while the FIFO is full, and picks up again on its own once the host reads a word.

The host reads one word per `rd_en` pulse. It can see the FIFO occupancy at all times. A synchronous clear command empties the FIFO and restarts production from a clean state. Changing the group or the mode while a word is partly packed discards that partial word, so every word holds samples from a single group under a single mode.

Top module: `ro_sample_packer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `word_count` is 0, `empty` is 1, `rd_data` is 0 and `underflow` is 0.
- R2: In raw mode (`raw_mode`=1), each cycle with `enable` high and room in the FIFO samples `src_bits[g*8+7:g*8]`, where g is `grp_sel`. The clock edge that takes the 8th sample pushes a word, and `word_count` rises at that same edge.
- R3: In a raw word, bit s*8+i holds sample s of source i of the group. Sample 0 is the oldest of the eight.
- R4: In non-raw mode, one word is pushed on every 81st enabled cycle. The words are successive states of a 64-bit LFSR. The first word is the seed 64'h0123456789ABCDEF. Each following word is the previous one shifted left by one bit, with bit 0 set to the XOR of old bits 63, 62, 60 and 59.
- R5: Nothing is sampled or pushed while `word_count` is 64. Sampling resumes in the cycle after a read frees a slot.
- R6: A cycle with `soft_clr` high empties the FIFO, discards any partial word and reloads the LFSR seed. In that cycle it also drives `rd_data` and `underflow` to 0, ignores `rd_en` and produces nothing.
- R7: A read of a non-empty FIFO returns the oldest word on `rd_data` after the edge. A read of an empty FIFO returns 0 and raises `underflow` for exactly that one cycle. `rd_data` holds its value between reads.
- R8: If `grp_sel` or `raw_mode` differs from the value latched at the start of the current partial word, that partial word is discarded. The sample taken in the cycle of the change becomes sample 0 of a new word.
- R9: A cycle with `enable` low discards any partial word. The first sample after `enable` rises is packed exactly as it arrives, with no special handling.
- R10: `word_count` equals the FIFO occupancy (0 to 64) and changes at the edge of each push or pop. `empty` is high exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_bits | input | 128 | Synchronized entropy source bits |
| grp_sel | input | 4 | Selected group of 8 sources |
| enable | input | 1 | Production enable |
| raw_mode | input | 1 | 1: raw packing, 0: LFSR stub |
| soft_clr | input | 1 | Synchronous clear command |
| rd_en | input | 1 | Read one word |
| rd_data | output | 64 | Word returned by the last read |
| empty | output | 1 | FIFO holds no words |
| underflow | output | 1 | Last read found the FIFO empty |
| word_count | output | 7 | FIFO occupancy |

## Verification
The bench feeds bytes with known values into the selected group and checks where each one lands in the word. A lane or order swap would show up as a byte-shuffled word. It switches the group in the middle of a word and drops `enable` in the middle of a word; a design that kept the stale partial word would return a word that mixes two groups. It fills the FIFO to 64 words and reads one out, which catches a design that overwrites the oldest word or stalls for good once full. It also reads an empty FIFO and clears while words are queued. A random phase then mixes all of these stimuli against a cycle-level model.

// File: rtl/ropk_pkg.sv
package ropk_pkg;
  localparam int unsigned WORD_BITS = 64;
  localparam logic [WORD_BITS-1:0] STUB_SEED = 64'h0123_4567_89AB_CDEF;

  // LFSR advance: shift left, feedback from taps 63, 62, 60, 59.
  function automatic logic [WORD_BITS-1:0] lfsr_adv(input logic [WORD_BITS-1:0] s);
    return {s[WORD_BITS-2:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  // Bit position of a lane inside a packed word.
  function automatic int unsigned lane_base(input int unsigned slot, input int unsigned lane_w);
    return slot * lane_w;
  endfunction
endpackage

// File: rtl/ropk_lfsr.sv
module ropk_lfsr
  import ropk_pkg::*;
#(
  parameter logic [WORD_BITS-1:0] SEED = STUB_SEED
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reload,
  input  logic                 step,
  output logic [WORD_BITS-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= SEED;
    else if (reload) state <= SEED;
    else if (step)   state <= lfsr_adv(state);
  end

  // R4: the stub state only moves when a word is taken from it
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !reload) |=> $stable(state));
endmodule

// File: rtl/ropk_sampler.sv
module ropk_sampler
  import ropk_pkg::*;
#(
  parameter int unsigned N_SRC       = 128,
  parameter int unsigned GRP_W       = 8,
  parameter int unsigned COND_CYCLES = 81,
  localparam int unsigned N_GRP      = N_SRC / GRP_W,
  localparam int unsigned GSW        = $clog2(N_GRP),
  localparam int unsigned SAMPLES    = WORD_BITS / GRP_W,
  localparam int unsigned CNT_MAX    = (SAMPLES > COND_CYCLES) ? SAMPLES : COND_CYCLES,
  localparam int unsigned CNTW       = $clog2(CNT_MAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 enable,
  input  logic                 raw_mode,
  input  logic [GSW-1:0]       grp_sel,
  input  logic [N_SRC-1:0]     src_bits,
  input  logic                 full,
  input  logic [WORD_BITS-1:0] lfsr_state,
  output logic                 push,
  output logic [WORD_BITS-1:0] push_word,
  output logic                 lfsr_step
);
  logic [CNTW-1:0]      cnt;
  logic [GSW-1:0]       cur_grp;
  logic                 cur_mode;
  logic [WORD_BITS-1:0] acc;
  logic [WORD_BITS-1:0] packed_word;
  logic [GRP_W-1:0]     sample;
  logic                 active, cfg_change, word_done;
  logic [CNTW-1:0]      slot, last_slot;

  assign sample     = src_bits[grp_sel*GRP_W +: GRP_W];
  assign active     = enable && !clr && !full;
  assign cfg_change = (cnt != '0) && ((grp_sel != cur_grp) || (raw_mode != cur_mode));
  assign slot       = cfg_change ? '0 : cnt;
  assign last_slot  = raw_mode ? CNTW'(SAMPLES - 1) : CNTW'(COND_CYCLES - 1);
  assign word_done  = active && (slot == last_slot);

  always_comb begin
    packed_word = acc;
    packed_word[lane_base(SAMPLES - 1, GRP_W) +: GRP_W] = sample;
  end

  assign push      = word_done;
  assign push_word = raw_mode ? packed_word : lfsr_state;
  assign lfsr_step = word_done && !raw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cur_grp  <= '0;
      cur_mode <= 1'b0;
      acc      <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else begin
      cnt <= word_done ? '0 : slot + 1'b1;
      if (slot == '0) begin
        cur_grp  <= grp_sel;
        cur_mode <= raw_mode;
      end
      if (raw_mode)
        for (int s = 0; s < SAMPLES; s++)
          if (slot == CNTW'(s)) acc[lane_base(s, GRP_W) +: GRP_W] <= sample;
    end
  end

  // R5: a word is never offered while the FIFO has no room
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R4: the stub only advances in non-raw mode
  p_step_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_step |-> !raw_mode);
  // R9: no partial word survives a disabled cycle
  p_disable_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt == '0);
endmodule

// File: rtl/ropk_fifo.sv
module ropk_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          underflow,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign pop   = rd_en && !clr && !empty;

  always_ff @(posedge clk)
    if (push && !clr) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      rd_data <= '0; underflow <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
      rd_data <= '0; underflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_data <= mem[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end else if (rd_en) begin
        rd_data <= '0;
      end
      underflow <= rd_en && empty;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10: occupancy never exceeds the depth
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R10: without a clear the occupancy moves by at most one per edge
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
              || (count == $past(count) - 1'b1)));
  // R7: underflow only follows a read of an empty FIFO
  p_underflow_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(rd_en && empty && !clr));
  // R6: a clear leaves the FIFO empty
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !underflow);
endmodule

// File: rtl/ro_sample_packer.sv
module ro_sample_packer
  import ropk_pkg::*;
#(
  parameter int unsigned N_SRC       = 128,
  parameter int unsigned GRP_W       = 8,
  parameter int unsigned FIFO_DEPTH  = 64,
  parameter int unsigned COND_CYCLES = 81
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N_SRC-1:0]                       src_bits,
  input  logic [$clog2(N_SRC/GRP_W)-1:0]         grp_sel,
  input  logic                                   enable,
  input  logic                                   raw_mode,
  input  logic                                   soft_clr,
  input  logic                                   rd_en,
  output logic [WORD_BITS-1:0]                   rd_data,
  output logic                                   empty,
  output logic                                   underflow,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]        word_count
);
  logic                 fifo_full, push, lfsr_step;
  logic [WORD_BITS-1:0] push_word, lfsr_state;

  ropk_sampler #(.N_SRC(N_SRC), .GRP_W(GRP_W), .COND_CYCLES(COND_CYCLES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .enable(enable), .raw_mode(raw_mode),
    .grp_sel(grp_sel), .src_bits(src_bits), .full(fifo_full), .lfsr_state(lfsr_state),
    .push(push), .push_word(push_word), .lfsr_step(lfsr_step));

  ropk_lfsr #(.SEED(STUB_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .reload(soft_clr), .step(lfsr_step), .state(lfsr_state));

  ropk_fifo #(.W(WORD_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .push(push), .push_data(push_word),
    .rd_en(rd_en), .rd_data(rd_data), .underflow(underflow), .full(fifo_full),
    .empty(empty), .count(word_count));
endmodule

// File: tb/ro_sample_packer_tb.sv
module ro_sample_packer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_bits = '0;
  logic [3:0]   grp_sel = '0;
  logic         enable = 1'b0, raw_mode = 1'b1, soft_clr = 1'b0, rd_en = 1'b0;
  logic [63:0]  rd_data;
  logic         empty, underflow;
  logic [6:0]   word_count;

  int vectors = 0, fails = 0;
  bit run_chk = 1'b0;

  always #4ns clk = ~clk;

  ro_sample_packer u_dut (.clk(clk), .rst_n(rst_n), .src_bits(src_bits), .grp_sel(grp_sel),
    .enable(enable), .raw_mode(raw_mode), .soft_clr(soft_clr), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .underflow(underflow), .word_count(word_count));

  localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] TAPS = 64'hD800_0000_0000_0000;

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] r = s << 1;
    r[0] = ^(s & TAPS);
    return r;
  endfunction

  // Cycle-level model built from the requirements.
  logic [63:0] mq[$];
  logic [63:0] m_acc, m_lfsr = SEED, exp_rd = '0;
  bit          exp_uf = 1'b0, m_mode = 1'b0;
  int          m_cnt = 0;
  logic [3:0]  m_grp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_cnt = 0; m_lfsr = SEED; exp_rd = '0; exp_uf = 1'b0;
    end else if (soft_clr) begin
      mq.delete(); m_cnt = 0; m_lfsr = SEED; exp_rd = '0; exp_uf = 1'b0;
    end else begin
      automatic bit was_full = (mq.size() == 64);
      exp_uf = 1'b0;
      if (rd_en) begin
        if (mq.size() == 0) begin exp_rd = '0; exp_uf = 1'b1; end
        else exp_rd = mq.pop_front();
      end
      if (enable && !was_full) begin
        if (m_cnt != 0 && (grp_sel != m_grp || raw_mode != m_mode)) m_cnt = 0;
        if (m_cnt == 0) begin m_grp = grp_sel; m_mode = raw_mode; end
        if (raw_mode) begin
          for (int i = 0; i < 8; i++) m_acc[m_cnt*8 + i] = src_bits[grp_sel*8 + i];
          if (m_cnt == 7) begin mq.push_back(m_acc); m_cnt = 0; end else m_cnt++;
        end else begin
          if (m_cnt == 80) begin mq.push_back(m_lfsr); m_lfsr = nxt(m_lfsr); m_cnt = 0; end
          else m_cnt++;
        end
      end else m_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_chk) begin
    chk("R10 word_count", 64'(word_count), 64'(mq.size()));
    chk("R10 empty", 64'(empty), 64'(mq.size() == 0));
    chk("R7/R3 rd_data", rd_data, exp_rd);
    chk("R7 underflow", 64'(underflow), 64'(exp_uf));
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic read1();
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8ns);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd77));
    tick(1);
    chk("R1 count in reset", 64'(word_count), 0);
    chk("R1 empty in reset", 64'(empty), 1);
    tick(1); rst_n = 1'b1; tick(1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 underflow", 64'(underflow), 0);
    run_chk = 1'b1;

    // R2/R3/R9: one word from group 3, first sample nonzero and kept verbatim
    enable = 1'b1; grp_sel = 4'd3; raw_mode = 1'b1;
    for (int s = 0; s < 8; s++) begin
      src_bits = {$urandom, $urandom, $urandom, $urandom};
      src_bits[24 +: 8] = 8'h11 * (s + 1);
      tick(1);
      if (s == 6) chk("R2 no word after 7 samples", 64'(word_count), 0);
    end
    enable = 1'b0;
    chk("R2 word after 8 samples", 64'(word_count), 1);
    read1();
    chk("R3 R9 layout", rd_data, 64'h8877_6655_4433_2211);

    // R8: group change mid-word discards the partial word
    enable = 1'b1; grp_sel = 4'd5;
    for (int s = 0; s < 3; s++) begin src_bits = {$urandom, $urandom, $urandom, $urandom}; tick(1); end
    grp_sel = 4'd6;
    for (int s = 0; s < 8; s++) begin
      src_bits = {$urandom, $urandom, $urandom, $urandom};
      src_bits[48 +: 8] = 8'hA0 + 8'(s);
      tick(1);
    end
    enable = 1'b0;
    chk("R8 one word only", 64'(word_count), 1);
    read1();
    chk("R8 word from new group", rd_data, 64'hA7A6_A5A4_A3A2_A1A0);

    // R9: enable drop discards the partial word
    enable = 1'b1; grp_sel = 4'd2;
    for (int s = 0; s < 4; s++) begin src_bits = {$urandom, $urandom, $urandom, $urandom}; tick(1); end
    enable = 1'b0; tick(1); enable = 1'b1;
    for (int s = 0; s < 8; s++) begin
      src_bits = {$urandom, $urandom, $urandom, $urandom};
      src_bits[16 +: 8] = 8'h50 + 8'(s);
      tick(1);
    end
    enable = 1'b0;
    chk("R9 one word after re-enable", 64'(word_count), 1);
    read1();
    chk("R9 word after re-enable", rd_data, 64'h5756_5554_5352_5150);

    // R5: fill, stall, resume after a read
    enable = 1'b1;
    for (int c = 0; c < 64 * 8 + 20; c++) begin src_bits = {$urandom, $urandom, $urandom, $urandom}; tick(1); end
    chk("R5 full", 64'(word_count), 64);
    read1();
    chk("R5 after pop", 64'(word_count), 63);
    tick(7);
    chk("R5 refill pending", 64'(word_count), 63);
    tick(1);
    chk("R5 refilled", 64'(word_count), 64);

    // R6: clear
    enable = 1'b0; soft_clr = 1'b1; tick(1); soft_clr = 1'b0;
    chk("R6 count cleared", 64'(word_count), 0);
    chk("R6 empty", 64'(empty), 1);
    chk("R6 rd_data", rd_data, 0);

    // R7: empty read
    read1();
    chk("R7 underflow pulse", 64'(underflow), 1);
    chk("R7 zero data", rd_data, 0);
    tick(1);
    chk("R7 underflow one cycle", 64'(underflow), 0);

    // R4: LFSR stub
    raw_mode = 1'b0; enable = 1'b1; soft_clr = 1'b1; tick(1); soft_clr = 1'b0;
    tick(80);
    chk("R4 no word before 81", 64'(word_count), 0);
    tick(1);
    chk("R4 word at 81", 64'(word_count), 1);
    tick(81);
    chk("R4 second word", 64'(word_count), 2);
    enable = 1'b0;
    read1();
    chk("R4 seed word", rd_data, SEED);
    read1();
    chk("R4 next word", rd_data, nxt(SEED));

    // Random mix checked against the model
    raw_mode = 1'b1; enable = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      src_bits = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(39) == 0) grp_sel = 4'($urandom);
      if ($urandom_range(299) == 0) raw_mode = ~raw_mode;
      enable   = ($urandom_range(19) != 0);
      rd_en    = ($urandom_range(5) == 0);
      soft_clr = ($urandom_range(499) == 0);
      tick(1);
    end
    rd_en = 1'b0; soft_clr = 1'b0; enable = 1'b0;
    tick(2);
    finish_run();
  end
endmodule